// File: doc/BRIEF.md
# Memory Access Sequencer

This block is the control machine that sits between a processor-side command port and a memory device. A requester raises a request flag together with a direction flag. The sequencer then runs one of three transactions: a single read cycle, a four-cycle burst read, or a single write cycle. Address generation and data steering are handled elsewhere. This block only produces the strobes that pace the memory.

While it performs a read, the sequencer holds a read strobe. For a write it produces two strobes. The first is a registered write strobe for the one cycle spent in the write state, which is clean and free of glitches. The second is an early write strobe that is decoded combinationally from the idle state and the live request inputs, and it rises one cycle ahead of the registered strobe. The burst flag is sampled in the first read cycle. When it is set there, three more read cycles follow. A coded state output shows the sequence that the machine is stepping through.

Top module: `mem_seq_ctrl`

## Requirements
- R1: With `srst` high at a rising edge, the next cycle shows `seq_state` = 0 (idle), `rd_en` = 0 and `wr_en` = 0, whatever the other inputs are. `wr_en_early` is 0 while `srst` is high.
- R2: In idle (`seq_state` = 0) with `req_valid` = 0, the machine stays in idle at the next edge.
- R3: In idle with `req_valid` = 1 and `req_read` = 1, the next state is the first read cycle (`seq_state` = 1).
- R4: In idle with `req_valid` = 1 and `req_read` = 0, the next state is the write cycle (`seq_state` = 5). The write cycle lasts exactly one cycle and always returns to idle.
- R5: `wr_en_early` is 1 exactly when the machine is in idle, `req_valid` = 1, `req_read` = 0 and `srst` = 0. It therefore leads `wr_en` by one cycle.
- R6: In the first read cycle with `req_burst` = 0, the next state is idle.
- R7: In the first read cycle with `req_burst` = 1, the states that follow are 2, 3 and 4, and then idle, whatever the inputs are. `rd_en` is therefore high for four consecutive cycles.
- R8: `rd_en` is 1 exactly in states 1 to 4, and `wr_en` is 1 exactly in state 5. The two are never high together.
- R9: A request held high while a transaction is running does not change the sequence. It is taken up only once the machine is back in idle.
- R10: `req_burst` has no effect in idle or in the write cycle. A read started with `req_burst` = 1 in idle and 0 in its first cycle is a single read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| srst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A memory access is requested |
| req_read | input | 1 | Direction: 1 read, 0 write |
| req_burst | input | 1 | Extend the read to four cycles (sampled in the first read cycle) |
| rd_en | output | 1 | Registered read strobe, high in every read cycle |
| wr_en | output | 1 | Registered write strobe, high in the write cycle |
| wr_en_early | output | 1 | Combinational early write strobe, high in idle when a write is requested |
| seq_state | output | 3 | State code: 0 idle, 1 to 4 read cycles one to four, 5 write |

## Verification
The bench holds a request high through a whole burst and through a write. A machine that listened to its inputs outside idle would restart a read or write partway through, and the state trace would show it. The bench toggles the burst flag in idle and during writes, and also flips it between idle and the first read cycle. A design that sampled the flag at the wrong time would stretch a single read into four cycles or cut a burst short. The early write strobe is checked just before each edge against the live inputs. An early strobe that ignored reset, or that was registered, would either fire during reset or arrive together with the registered strobe instead of one cycle ahead of it. A reset applied in the middle of a burst must bring the machine back to idle in one cycle.

// File: rtl/mem_seq_pkg.sv
package mem_seq_pkg;

    localparam int STATE_W    = 3;
    localparam int BURST_LEN  = 4;
    localparam int RUN_CNT_W  = $clog2(BURST_LEN + 1);

    // State codes are visible on seq_state, so their values are fixed.
    typedef enum logic [STATE_W-1:0] {
        ST_IDLE = 3'd0,
        ST_RD1  = 3'd1,
        ST_RD2  = 3'd2,
        ST_RD3  = 3'd3,
        ST_RD4  = 3'd4,
        ST_WR   = 3'd5
    } seq_state_e;

    // Everything the sequencer registers each cycle.
    typedef struct packed {
        seq_state_e state;
        logic       rd_en;
        logic       wr_en;
    } seq_regs_t;

    localparam seq_regs_t SEQ_REGS_RST = '{state: ST_IDLE, rd_en: 1'b0, wr_en: 1'b0};

    function automatic logic is_read_state(input seq_state_e s);
        return (s == ST_RD1) || (s == ST_RD2) || (s == ST_RD3) || (s == ST_RD4);
    endfunction

endpackage

// File: rtl/mem_seq_next.sv
// Next-value logic: works out the next state and the registered strobes
// that go with it. Purely combinational.
module mem_seq_next
    import mem_seq_pkg::*;
(
    input  seq_state_e cur_state,
    input  logic       srst,
    input  logic       req_valid,
    input  logic       req_read,
    input  logic       req_burst,
    output seq_regs_t  regs_d
);

    seq_state_e state_nx;

    always_comb begin
        state_nx = ST_IDLE;
        case (cur_state)
            ST_IDLE: begin
                if (req_valid) begin
                    state_nx = req_read ? ST_RD1 : ST_WR;
                end else begin
                    state_nx = ST_IDLE;
                end
            end
            // The burst flag is only sampled in the first read cycle.
            ST_RD1:  state_nx = req_burst ? ST_RD2 : ST_IDLE;
            ST_RD2:  state_nx = ST_RD3;
            ST_RD3:  state_nx = ST_RD4;
            ST_RD4:  state_nx = ST_IDLE;
            ST_WR:   state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase

        if (srst) begin
            regs_d = SEQ_REGS_RST;
        end else begin
            regs_d.state = state_nx;
            // Strobes are decoded from the next state so they leave the flop
            // aligned with the state they belong to.
            regs_d.rd_en = is_read_state(state_nx);
            regs_d.wr_en = (state_nx == ST_WR);
        end
    end

endmodule

// File: rtl/mem_seq_reg.sv
// Register stage: holds the whole next-value struct.
module mem_seq_reg
    import mem_seq_pkg::*;
(
    input  logic      clk,
    input  seq_regs_t regs_d,
    output seq_regs_t regs_q
);

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

endmodule

// File: rtl/mem_seq_early.sv
// Input-dependent write strobe, valid in the idle cycle that precedes a write.
module mem_seq_early
    import mem_seq_pkg::*;
(
    input  seq_state_e cur_state,
    input  logic       srst,
    input  logic       req_valid,
    input  logic       req_read,
    output logic       wr_early
);

    always_comb begin
        wr_early = (cur_state == ST_IDLE) && req_valid && !req_read && !srst;
    end

endmodule

// File: rtl/mem_seq_ctrl.sv
module mem_seq_ctrl
    import mem_seq_pkg::*;
(
    input  logic               clk,
    input  logic               srst,
    input  logic               req_valid,
    input  logic               req_read,
    input  logic               req_burst,
    output logic               rd_en,
    output logic               wr_en,
    output logic               wr_en_early,
    output logic [STATE_W-1:0] seq_state
);

    seq_regs_t regs_d;
    seq_regs_t regs_q;

    mem_seq_next next_i (
        .cur_state (regs_q.state),
        .srst      (srst),
        .req_valid (req_valid),
        .req_read  (req_read),
        .req_burst (req_burst),
        .regs_d    (regs_d)
    );

    mem_seq_reg reg_i (
        .clk    (clk),
        .regs_d (regs_d),
        .regs_q (regs_q)
    );

    mem_seq_early early_i (
        .cur_state (regs_q.state),
        .srst      (srst),
        .req_valid (req_valid),
        .req_read  (req_read),
        .wr_early  (wr_en_early)
    );

    assign rd_en     = regs_q.rd_en;
    assign wr_en     = regs_q.wr_en;
    assign seq_state = regs_q.state;

endmodule

// File: rtl/mem_seq_ctrl_chk.sv
module mem_seq_ctrl_chk
    import mem_seq_pkg::*;
(
    input logic               clk,
    input logic               srst,
    input logic               req_valid,
    input logic               req_read,
    input logic               req_burst,
    input logic               rd_en,
    input logic               wr_en,
    input logic               wr_en_early,
    input logic [STATE_W-1:0] seq_state
);

    logic [RUN_CNT_W-1:0] rd_run_q;

    always_ff @(posedge clk) begin
        if (srst) begin
            rd_run_q <= '0;
        end else if (rd_en) begin
            rd_run_q <= rd_run_q + 1'b1;
        end else begin
            rd_run_q <= '0;
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        srst |=> (seq_state == 3'd0 && !rd_en && !wr_en));

    // R1
    early_quiet_in_reset_chk: assert property (@(posedge clk)
        srst |-> !wr_en_early);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (srst)
        (seq_state == 3'd0 && !req_valid) |=> seq_state == 3'd0);

    // R3
    read_start_chk: assert property (@(posedge clk) disable iff (srst)
        (seq_state == 3'd0 && req_valid && req_read) |=> (seq_state == 3'd1 && rd_en));

    // R4
    write_start_chk: assert property (@(posedge clk) disable iff (srst)
        (seq_state == 3'd0 && req_valid && !req_read) |=> (seq_state == 3'd5 && wr_en));

    // R4
    write_single_chk: assert property (@(posedge clk) disable iff (srst)
        (seq_state == 3'd5) |=> seq_state == 3'd0);

    // R5
    early_leads_chk: assert property (@(posedge clk) disable iff (srst)
        wr_en_early |=> wr_en);

    // R6
    single_read_chk: assert property (@(posedge clk) disable iff (srst)
        (seq_state == 3'd1 && !req_burst) |=> seq_state == 3'd0);

    // R7
    burst_step_chk: assert property (@(posedge clk) disable iff (srst)
        (seq_state == 3'd1 && req_burst) |=> seq_state == 3'd2);

    // R7
    burst_run_chk: assert property (@(posedge clk) disable iff (srst)
        (seq_state == 3'd2 || seq_state == 3'd3) |=> seq_state == $past(seq_state) + 3'd1);

    // R7
    burst_end_chk: assert property (@(posedge clk) disable iff (srst)
        (seq_state == 3'd4) |=> seq_state == 3'd0);

    // R7
    read_run_limit_chk: assert property (@(posedge clk) disable iff (srst)
        rd_en |-> rd_run_q < RUN_CNT_W'(BURST_LEN));

    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (srst)
        !(rd_en && wr_en));

    // R8
    rd_match_chk: assert property (@(posedge clk) disable iff (srst)
        rd_en == (seq_state >= 3'd1 && seq_state <= 3'd4));

endmodule

bind mem_seq_ctrl mem_seq_ctrl_chk chk_i (
    .clk         (clk),
    .srst        (srst),
    .req_valid   (req_valid),
    .req_read    (req_read),
    .req_burst   (req_burst),
    .rd_en       (rd_en),
    .wr_en       (wr_en),
    .wr_en_early (wr_en_early),
    .seq_state   (seq_state)
);

// File: tb/mem_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module mem_seq_ctrl_tb_top;

    localparam real CLK_HALF = 4.0;
    localparam int  MAX_CYC  = 200000;

    logic       clk = 1'b0;
    logic       srst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_read = 1'b0;
    logic       req_burst = 1'b0;
    logic       rd_en;
    logic       wr_en;
    logic       wr_en_early;
    logic [2:0] seq_state;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    int mst   = 0;   // model state code

    always #(CLK_HALF) clk = ~clk;

    mem_seq_ctrl dut_i (
        .clk         (clk),
        .srst        (srst),
        .req_valid   (req_valid),
        .req_read    (req_read),
        .req_burst   (req_burst),
        .rd_en       (rd_en),
        .wr_en       (wr_en),
        .wr_en_early (wr_en_early),
        .seq_state   (seq_state)
    );

    task automatic chk(input string tag, input string scen, input integer act, input integer exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s [%s] t=%0t act=%0d exp=%0d", tag, scen, $time, act, exp);
        end
    endtask

    // One clock of stimulus with model comparison.
    task automatic step(input string scen, input bit v, input bit r, input bit b, input bit rs);
        int    prev;
        int    nst;
        string tag;
        @(negedge clk);
        req_valid = v; req_read = r; req_burst = b; srst = rs;
        #1;
        chk("R5", scen, wr_en_early, (!rs && mst == 0 && v && !r) ? 1 : 0);
        prev = mst;
        if (rs) nst = 0;
        else begin
            case (prev)
                0: nst = v ? (r ? 1 : 5) : 0;
                1: nst = b ? 2 : 0;
                2: nst = 3;
                3: nst = 4;
                default: nst = 0;
            endcase
        end
        if (rs) tag = "R1";
        else if (prev == 0) tag = !v ? "R2" : (r ? "R3" : "R4");
        else if (prev == 1) tag = b ? "R7" : "R6";
        else if (prev == 5) tag = "R4";
        else tag = "R7";
        @(posedge clk);
        #1;
        mst = nst;
        chk(tag, scen, seq_state, nst);
        chk("R8", scen, rd_en, (nst >= 1 && nst <= 4) ? 1 : 0);
        chk("R8", scen, wr_en, (nst == 5) ? 1 : 0);
    endtask

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        // R1: reset with hostile inputs
        step("R1", 1, 0, 1, 1);
        step("R1", 1, 1, 1, 1);
        // R2: idle without request
        for (int i = 0; i < 3; i++) step("R2", 0, i[0], 1, 0);
        // R3/R6: single read
        step("R3", 1, 1, 0, 0);
        step("R6", 0, 0, 0, 0);
        step("R2", 0, 0, 0, 0);
        // R7/R9: burst with the request held high throughout
        step("R3", 1, 1, 0, 0);
        step("R7", 1, 1, 1, 0);
        step("R9", 1, 0, 0, 0);
        step("R9", 1, 0, 1, 0);
        step("R9", 1, 0, 0, 0);
        // R9: held request picked up again in idle -> write
        step("R9", 1, 0, 1, 0);
        step("R10", 1, 0, 1, 0);
        // R4: back-to-back writes
        step("R4", 1, 0, 0, 0);
        step("R4", 1, 1, 0, 0);
        step("R6", 0, 0, 0, 0);
        // R10: burst in idle, dropped in first read -> single read
        step("R10", 1, 1, 1, 0);
        step("R10", 0, 0, 0, 0);
        step("R2", 0, 0, 0, 0);
        // R1: reset in the middle of a burst
        step("R3", 1, 1, 0, 0);
        step("R7", 0, 0, 1, 0);
        step("R1", 1, 0, 0, 1);
        step("R2", 0, 0, 0, 0);
        // mixed pseudo-random traffic
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step("mix", lfsr[0], lfsr[3], lfsr[6], lfsr[11:8] == 4'd0);
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(2.0 * CLK_HALF * MAX_CYC);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule